// File: doc/BRIEF.md
# Event-Triggered Beep Pulse Generator

This block produces a single active-high beep enable that stays high for a fixed number of milliseconds after any of five system events. Four of the events arrive as levels and the block reacts to one transition of each: the initialisation line dropping low (battery change or power-on), a memory-key line rising, the emergency-channel switch line rising, and the new-channel line rising. The fifth input is the hold-mode level, and leaving hold (its falling edge) also sounds the beep. The block does not make the tone. A separate tone source is gated by `beep`.

The pulse length is counted in ticks of a one-millisecond strobe supplied from outside, and the parameter `BEEP_MS` (default 50) sets how many ticks that is. Any event that arrives while the pulse is running restarts the full interval. An event that coincides with a tick takes priority, so that tick is not counted.

Top module: `beep_pulse_gen`

## Requirements
- R1: While `rstN` is low, `beep` is 0. After `rstN` rises, `beep` stays 0 until an event occurs.
- R2: A high-to-low transition of `initN` is an event. If `initN` is already low when reset is released, the first clock edge after release counts as an event.
- R3: A low-to-high transition of `memKey` is an event.
- R4: A low-to-high transition of `emergSw` is an event.
- R5: A low-to-high transition of `newChan` is an event.
- R6: A high-to-low transition of `holdIn` (leaving hold) is an event. A rise of `holdIn`, or `holdIn` being high when reset is released, is not an event.
- R7: `beep` goes to 1 on the clock edge that samples an event. It stays 1 through exactly `BEEP_MS` later edges that sample `tickMs` high, and it returns to 0 on the edge that samples the `BEEP_MS`-th such tick.
- R8: An event while `beep` is 1 reloads the full `BEEP_MS` interval. If an event and `tickMs` are sampled on the same edge, the event wins and that tick is not counted.
- R9: Only the listed transitions are events. Holding an input at its trigger level, or moving it in the other direction, has no effect on `beep`.
- R10: Ticks sampled while `beep` is 0 have no effect. The next pulse still lasts a full `BEEP_MS` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickMs | input | 1 | One-cycle strobe, once per millisecond |
| initN | input | 1 | Initialisation level; falling edge is an event |
| memKey | input | 1 | Memory-key press level; rising edge is an event |
| emergSw | input | 1 | Emergency-channel switch level; rising edge is an event |
| newChan | input | 1 | New-channel-selected level; rising edge is an event |
| holdIn | input | 1 | Hold-mode level; falling edge is an event |
| beep | output | 1 | Active-high beep enable |

## Verification
The hardest situation to reach is an event that lands on the same edge as a tick while the pulse is running, especially when it is the last tick that would have ended the pulse. The stimulus reaches it by reading the tick phase half a cycle before each edge. For every ordered pair of event sources, and for every gap from zero to just past `BEEP_MS` ticks, it fires the second event either on a tick edge or between ticks. The expected number of ticks seen high is derived from how many ticks were consumed before the second event.

// File: rtl/beep_pkg.sv
package beep_pkg;

  // Event slots inside the packed level vector.
  localparam int EVT_COUNT = 5;
  localparam int EV_INIT   = 0;
  localparam int EV_MEMKEY = 1;
  localparam int EV_EMERG  = 2;
  localparam int EV_NEWCH  = 3;
  localparam int EV_HOLD   = 4;

  // 1 = the slot fires on a falling edge, 0 = on a rising edge.
  localparam logic [EVT_COUNT-1:0] FALL_MASK   = 5'b10001;
  // Level the previous-sample flop assumes at reset.
  localparam logic [EVT_COUNT-1:0] RESET_LEVEL = 5'b00001;

  // Strobes from control to the pulse datapath.
  typedef struct packed {
    logic load;   // restart the full interval
    logic step;   // consume one millisecond
  } beepStrobe_t;

endpackage

// File: rtl/beep_edge_detect.sv
module beep_edge_detect #(
  parameter int unsigned N = 5,
  parameter logic [N-1:0] FALL_MASK   = '0,
  parameter logic [N-1:0] RESET_LEVEL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] levelIn,
  output logic [N-1:0] hitVec
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prevLvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevLvl <= RESET_LEVEL[i];
      else       prevLvl <= levelIn[i];
    end

    if (FALL_MASK[i]) begin : g_fall
      assign hitVec[i] = prevLvl & ~levelIn[i];
    end else begin : g_rise
      assign hitVec[i] = ~prevLvl & levelIn[i];
    end
  end

endmodule

// File: rtl/beep_ctrl.sv
module beep_ctrl
  import beep_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic         tickMs,
  input  logic         active,
  input  logic [N-1:0] hitVec,
  output beepStrobe_t  strb
);

  logic anyHit;

  assign anyHit    = |hitVec;
  // A fresh event overrides a tick on the same edge.
  assign strb.load = anyHit;
  assign strb.step = tickMs & active & ~anyHit;

endmodule

// File: rtl/beep_timer.sv
module beep_timer
  import beep_pkg::*;
#(
  parameter int unsigned BEEP_MS = 50,
  parameter int unsigned CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  beepStrobe_t      strb,
  output logic [CNT_W-1:0] remaining,
  output logic             active,
  output logic             beepOut
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BEEP_MS);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          remaining <= '0;
    else if (strb.load) remaining <= LOAD_VAL;
    else if (strb.step) remaining <= remaining - LAST_VAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   beepOut <= 1'b0;
    else if (strb.load)                          beepOut <= 1'b1;
    else if (strb.step && remaining == LAST_VAL) beepOut <= 1'b0;
  end

  assign active = (remaining != '0);

endmodule

// File: rtl/beep_pulse_gen.sv
module beep_pulse_gen
  import beep_pkg::*;
#(
  parameter int unsigned BEEP_MS = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickMs,
  input  logic initN,
  input  logic memKey,
  input  logic emergSw,
  input  logic newChan,
  input  logic holdIn,
  output logic beep
);

  localparam int unsigned CNT_W = $clog2(BEEP_MS + 1);

  logic [EVT_COUNT-1:0] levelVec;
  logic [EVT_COUNT-1:0] hitVec;
  logic [CNT_W-1:0]     remaining;
  logic                 active;
  beepStrobe_t          strb;

  assign levelVec[EV_INIT]   = initN;
  assign levelVec[EV_MEMKEY] = memKey;
  assign levelVec[EV_EMERG]  = emergSw;
  assign levelVec[EV_NEWCH]  = newChan;
  assign levelVec[EV_HOLD]   = holdIn;

  beep_edge_detect #(
    .N(EVT_COUNT), .FALL_MASK(FALL_MASK), .RESET_LEVEL(RESET_LEVEL)
  ) u_edge (
    .clk(clk), .rstN(rstN), .levelIn(levelVec), .hitVec(hitVec)
  );

  beep_ctrl #(.N(EVT_COUNT)) u_ctrl (
    .tickMs(tickMs), .active(active), .hitVec(hitVec), .strb(strb)
  );

  beep_timer #(.BEEP_MS(BEEP_MS), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rstN(rstN), .strb(strb),
    .remaining(remaining), .active(active), .beepOut(beep)
  );

endmodule

// File: rtl/beep_pulse_gen_chk.sv
module beep_pulse_gen_chk #(
  parameter int unsigned BEEP_MS = 50,
  parameter int unsigned CNT_W   = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickMs,
  input logic             initN,
  input logic             memKey,
  input logic             emergSw,
  input logic             newChan,
  input logic             holdIn,
  input logic             beep,
  input logic [CNT_W-1:0] remaining
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BEEP_MS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic postRst;
  logic prvInit, prvKey, prvEmerg, prvChan, prvHold;
  logic anyEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) postRst <= 1'b0;
    else       postRst <= 1'b1;
  end

  always_ff @(posedge clk) begin
    prvInit  <= initN;
    prvKey   <= memKey;
    prvEmerg <= emergSw;
    prvChan  <= newChan;
    prvHold  <= holdIn;
  end

  assign anyEvt = (prvInit & ~initN) | (~prvKey & memKey) | (~prvEmerg & emergSw)
                | (~prvChan & newChan) | (prvHold & ~holdIn);

  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!beep);
    end
  end

  p_init_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    postRst && prvInit && !initN |=> beep && remaining == FULL);

  p_key_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    postRst && !prvKey && memKey |=> beep && remaining == FULL);

  p_emerg_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    postRst && !prvEmerg && emergSw |=> beep && remaining == FULL);

  p_chan_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    postRst && !prvChan && newChan |=> beep && remaining == FULL);

  p_hold_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    postRst && prvHold && !holdIn |=> beep && remaining == FULL);

  p_tick_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    postRst && !anyEvt && tickMs && remaining > ONE |=> beep && remaining == $past(remaining) - ONE);

  p_pulse_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    postRst && !anyEvt && tickMs && remaining == ONE |=> !beep);

  p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    postRst && beep && !anyEvt && !tickMs |=> beep && $stable(remaining));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    postRst && !beep && !anyEvt |=> !beep);

  p_overflow_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    remaining <= FULL);

endmodule

bind beep_pulse_gen beep_pulse_gen_chk #(.BEEP_MS(BEEP_MS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickMs(tickMs), .initN(initN), .memKey(memKey),
  .emergSw(emergSw), .newChan(newChan), .holdIn(holdIn), .beep(beep),
  .remaining(remaining)
);

// File: tb/beep_pulse_gen_bench.sv
module beep_pulse_gen_bench;

  localparam int BEEP_MS  = 5;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0;
  logic rstN;
  logic tickMs = 1'b0;
  logic initN, memKey, emergSw, newChan, holdIn;
  logic beep;

  int nChecks = 0;
  int nBad = 0;
  int hiTicks = 0;
  int allTicks = 0;
  int tickPh = 0;
  bit monOn = 1'b0;
  string curTag = "R7";

  // Reference state
  int mCnt;
  logic mpInit, mpKey, mpEm, mpCh, mpHold;

  always #10 clk = ~clk;

  beep_pulse_gen #(.BEEP_MS(BEEP_MS)) u_beep_pulse_gen (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .initN(initN), .memKey(memKey),
    .emergSw(emergSw), .newChan(newChan), .holdIn(holdIn), .beep(beep)
  );

  always @(negedge clk) begin
    tickMs <= (tickPh == TICK_DIV - 1);
    tickPh <= (tickPh == TICK_DIV - 1) ? 0 : tickPh + 1;
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; mpInit <= 1'b1; mpKey <= 1'b0; mpEm <= 1'b0; mpCh <= 1'b0; mpHold <= 1'b0;
    end else begin
      if ((mpInit && !initN) || (!mpKey && memKey) || (!mpEm && emergSw) ||
          (!mpCh && newChan) || (mpHold && !holdIn))
        mCnt <= BEEP_MS;
      else if (tickMs && mCnt != 0)
        mCnt <= mCnt - 1;
      mpInit <= initN; mpKey <= memKey; mpEm <= emergSw; mpCh <= newChan; mpHold <= holdIn;
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (monOn && rstN === 1'b1)
      chk(curTag, int'(beep), int'(mCnt != 0), "beep against cycle model");
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  task automatic nextNeg();
    @(negedge clk);
    #1;
    if (tickMs) begin
      allTicks++;
      if (beep) hiTicks++;
    end
  endtask

  // trig=1 drives the source to its trigger level, trig=0 to its idle level.
  task automatic setSrc(int s, bit trig);
    case (s)
      0: initN = !trig;
      1: memKey = trig;
      2: emergSw = trig;
      3: newChan = trig;
      default: holdIn = !trig;
    endcase
  endtask

  function automatic string srcTag(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic waitLow();
    for (int i = 0; i < BEEP_MS * TICK_DIV * 4 && beep; i++) nextNeg();
    repeat (2) nextNeg();
  endtask

  task automatic doReset(bit initLvl, bit holdLvl);
    nextNeg();
    rstN = 1'b0;
    initN = initLvl; holdIn = holdLvl;
    memKey = 1'b0; emergSw = 1'b0; newChan = 1'b0;
    for (int i = 0; i < 3; i++) begin
      nextNeg();
      chk("R1", int'(beep), 0, "beep during reset");
    end
    rstN = 1'b1;
    hiTicks = 0; allTicks = 0;
  endtask

  task automatic single(int s, string onTag, string durTag);
    nextNeg();
    setSrc(s, 1'b1);
    hiTicks = 0;
    nextNeg();
    chk(onTag, int'(beep), 1, "beep after event");
    setSrc(s, 1'b0);
    waitLow();
    chk(durTag, hiTicks, BEEP_MS, "ticks counted while beep high");
  endtask

  task automatic scen(int a, int b, int d, bit coinc);
    int aVal;
    int cVal;
    int expT;
    nextNeg();
    setSrc(a, 1'b1);
    hiTicks = 0; allTicks = 0;
    nextNeg();
    setSrc(a, 1'b0);
    if (coinc) begin
      do nextNeg(); while (!(tickMs && allTicks >= d));
    end else begin
      do nextNeg(); while (allTicks < d || tickMs);
    end
    aVal = allTicks;
    cVal = int'(tickMs);
    setSrc(b, 1'b1);
    nextNeg();
    setSrc(b, 1'b0);
    waitLow();
    expT = (aVal - cVal < BEEP_MS) ? aVal + BEEP_MS : 2 * BEEP_MS;
    chk("R8", hiTicks, expT, $sformatf("ticks high src %0d->%0d gap %0d coinc %0d", a, b, d, coinc));
    chk("R8", int'(beep), 0, "beep low after retrigger scenario");
  endtask

  initial begin
    rstN = 1'b0;
    initN = 1'b1; memKey = 1'b0; emergSw = 1'b0; newChan = 1'b0; holdIn = 1'b0;

    // R1: quiet reset and release
    doReset(1'b1, 1'b0);
    monOn = 1'b1;
    repeat (12) nextNeg();
    chk("R1", int'(beep), 0, "beep idle after release");

    // R6: rising hold does not beep
    curTag = "R6";
    holdIn = 1'b1;
    repeat (12) nextNeg();
    chk("R6", int'(beep), 0, "beep after hold rise");

    // R2: initN low across reset release
    curTag = "R2";
    doReset(1'b0, 1'b0);
    nextNeg();
    chk("R2", int'(beep), 1, "beep after release with initN low");
    initN = 1'b1;
    waitLow();
    chk("R7", hiTicks, BEEP_MS, "ticks high after power-on beep");

    // R6: hold high at reset release is not an event
    curTag = "R6";
    doReset(1'b1, 1'b1);
    repeat (12) nextNeg();
    chk("R6", int'(beep), 0, "beep with hold high at release");

    // R3..R6 single events, R7 duration
    curTag = "R7";
    for (int s = 0; s < 5; s++) single(s, srcTag(s), "R7");

    // R9: held trigger level and reverse transitions
    curTag = "R9";
    nextNeg();
    memKey = 1'b1;
    hiTicks = 0;
    repeat (BEEP_MS * TICK_DIV * 3) nextNeg();
    chk("R9", hiTicks, BEEP_MS, "held key gives one pulse");
    chk("R9", int'(beep), 0, "beep low while key held");
    memKey = 1'b0;
    initN = 1'b0;
    repeat (4) nextNeg();
    hiTicks = 0;
    waitLow();
    initN = 1'b1;
    repeat (12) nextNeg();
    chk("R9", int'(beep), 0, "beep after key fall and init rise");

    // R10: long idle with ticks, then a full pulse
    curTag = "R10";
    repeat (10 * TICK_DIV) nextNeg();
    chk("R10", int'(beep), 0, "beep during idle ticks");
    single(3, "R5", "R10");

    // R8 sweep over source pairs, gaps and tick alignment
    curTag = "R8";
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int d = 0; d <= BEEP_MS + 1; d++)
          for (int c = 0; c < 2; c++)
            scen(a, b, d, c[0]);

    monOn = 1'b0;
    summary();
    $finish;
  end

endmodule